// File: doc/BRIEF.md
# Iterative Refinement Solver Sequencer

This block runs a mixed-precision refinement loop for a linear system A·x = b. It keeps a full-precision solution vector and a full-precision residual vector. Each pass sends a coarse 4-bit image of the residual to an external approximate-inverse unit and adds the returned increment to the solution. It then has an external exact matrix-vector unit multiply that increment by A and subtracts the product from the residual. After that it decides from the residual's magnitude whether to stop.

Before the residual goes out, it is scaled by a power-of-two right shift. The shift is picked so that the largest element just fits the signed 4-bit range, and the shift amount is sent along so that the inverse unit can scale its result back. The residual's size is estimated as the bit position of the leading one of its largest absolute element. The loop ends when that estimate falls below a programmable threshold, or when a programmable pass limit is reached. A flag records which of the two ended it.

Top module: `refine_seq`

## Requirements
- R1: A start_i pulse while idle sets the solution to zero and the residual to b_i. busy_o then stays high until the pass that ends the run has completed. After reset, busy_o, done_o, conv_o, nconv_o, both request outputs, iter_o and x_o are all zero.
- R2: Let L be the leading-one position of the largest |r_i| (L = 0 when r is all zero). The shift s is L-2 when L >= 3, otherwise 0. Element i of inv_vec_o, at bits [4i+3:4i], is the low 4 bits of r_i arithmetically shifted right by s. inv_shift_o equals s.
- R3: Each pass raises inv_req_o for exactly one cycle. inv_ack_i is only taken in the cycle after the request or later, and it captures inv_dx_i as the increment.
- R4: The captured increment is added, element by element with W-bit wrap, to the solution shown on x_o.
- R5: After the solution update, mvm_req_o pulses for one cycle while mvm_vec_o carries the captured increment. When mvm_ack_i arrives, mvm_res_i is subtracted element by element from the residual.
- R6: After each residual update, the run has converged if every |r_i| < 2^tol_i. On convergence, done_o pulses for one cycle and conv_o goes high.
- R7: If the run has not converged and iter_o >= max_iter_i, it stops with nconv_o high. At least one pass always runs, so max_iter_i = 0 behaves as 1.
- R8: iter_o counts completed passes and is cleared by an accepted start.
- R9: start_i and b_i are ignored while busy. The run in progress, its requests and its results are not changed by them.
- R10: conv_o and nconv_o are never high together. They hold their value after done_o until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a solve (taken only when idle) |
| b_i | input | N*W | Right-hand side, element i at [W*i +: W], two's complement |
| tol_i | input | LW | Threshold exponent: converged when all abs(r_i) < 2^tol_i |
| max_iter_i | input | IW | Pass limit |
| inv_req_o | output | 1 | One-cycle request to the approximate-inverse unit |
| inv_vec_o | output | N*QW | Quantized residual, 4-bit signed per element |
| inv_shift_o | output | LW | Right shift applied to form inv_vec_o |
| inv_ack_i | input | 1 | Increment valid |
| inv_dx_i | input | N*W | Increment from the approximate-inverse unit |
| mvm_req_o | output | 1 | One-cycle request to the matrix-vector unit |
| mvm_vec_o | output | N*W | Increment to be multiplied by A |
| mvm_ack_i | input | 1 | Product valid |
| mvm_res_i | input | N*W | Product A times increment |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle end-of-solve pulse |
| conv_o | output | 1 | Last solve met the threshold |
| nconv_o | output | 1 | Last solve hit the pass limit |
| iter_o | output | IW | Completed passes |
| x_o | output | N*W | Solution vector |

## Verification
Right-hand sides with mixed signs and a spread of magnitudes exercise the shift selection and the sign handling of the quantizer. A vector holding the most negative value checks the absolute-value width. A small vector stays below the shift threshold and so forces a stall that only the pass limit can end, which tells the two stop paths apart. An all-zero vector converges after one pass, and a zero pass limit shows the one-pass minimum. A run that gets a second start and a new b mid-solve shows that the state in flight is protected, since every request and the final solution still follow the unperturbed reference.

// File: rtl/refine_pkg.sv
package refine_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEND_INV, ST_WAIT_INV, ST_UPD_X,
    ST_SEND_MVM, ST_WAIT_MVM, ST_UPD_R, ST_CHECK, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/refine_norm.sv
module refine_norm #(
  parameter int N  = 4,
  parameter int W  = 24,
  parameter int QW = 4,
  parameter int LW = 5
) (
  input  logic [N*W-1:0]  r_i,
  input  logic [LW-1:0]   tol_i,
  output logic [N*QW-1:0] q_o,
  output logic [LW-1:0]   shift_o,
  output logic            conv_o
);
  logic [W:0]    mag_max;
  logic [LW-1:0] lead;
  logic          nz;

  always_comb begin
    mag_max = '0;
    for (int i = 0; i < N; i++) begin
      logic signed [W:0] ext;
      logic [W:0]        mag;
      ext = {r_i[i*W+W-1], r_i[i*W +: W]};
      mag = ext[W] ? $unsigned(-ext) : $unsigned(ext);
      if (mag > mag_max) mag_max = mag;
    end
    lead = '0;
    for (int b = 0; b <= W; b++)
      if (mag_max[b]) lead = LW'(b);
    nz = |mag_max;
  end

  // magnitude < 2^(lead+1) must land below 2^(QW-1)
  assign shift_o = (lead >= LW'(QW-1)) ? lead - LW'(QW-2) : '0;
  assign conv_o  = !nz || (lead < tol_i);

  for (genvar g = 0; g < N; g++) begin : g_quant
    logic signed [W-1:0] sh;
    assign sh = $signed(r_i[g*W +: W]) >>> shift_o;
    assign q_o[g*QW +: QW] = sh[QW-1:0];
  end
endmodule

// File: rtl/refine_vec.sv
module refine_vec #(
  parameter int N = 4,
  parameter int W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N*W-1:0] b_i,
  input  logic           cap_dx_i,
  input  logic [N*W-1:0] dx_i,
  input  logic           cap_p_i,
  input  logic [N*W-1:0] p_i,
  input  logic           upd_x_i,
  input  logic           upd_r_i,
  output logic [N*W-1:0] x_o,
  output logic [N*W-1:0] r_o,
  output logic [N*W-1:0] dx_o
);
  for (genvar g = 0; g < N; g++) begin : g_el
    logic [W-1:0] x_q, r_q, dx_q, p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q <= '0; r_q <= '0; dx_q <= '0; p_q <= '0;
      end else begin
        if (load_i) begin
          x_q <= '0;
          r_q <= b_i[g*W +: W];
        end else begin
          if (upd_x_i) x_q <= x_q + dx_q;
          if (upd_r_i) r_q <= r_q - p_q;
        end
        if (cap_dx_i) dx_q <= dx_i[g*W +: W];
        if (cap_p_i)  p_q  <= p_i[g*W +: W];
      end
    end
    assign x_o[g*W +: W]  = x_q;
    assign r_o[g*W +: W]  = r_q;
    assign dx_o[g*W +: W] = dx_q;
  end
endmodule

// File: rtl/refine_ctrl.sv
module refine_ctrl
  import refine_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          inv_ack_i,
  input  logic          mvm_ack_i,
  input  logic          conv_hit_i,
  input  logic [IW-1:0] max_iter_i,
  output logic          load_o,
  output logic          inv_req_o,
  output logic          cap_dx_o,
  output logic          upd_x_o,
  output logic          mvm_req_o,
  output logic          cap_p_o,
  output logic          upd_r_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          conv_o,
  output logic          nconv_o,
  output logic [IW-1:0] iter_o
);
  seq_state_e st_q, st_d;
  logic [IW-1:0] iter_q;
  logic conv_q, nconv_q;

  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign inv_req_o = (st_q == ST_SEND_INV);
  assign cap_dx_o  = (st_q == ST_WAIT_INV) && inv_ack_i;
  assign upd_x_o   = (st_q == ST_UPD_X);
  assign mvm_req_o = (st_q == ST_SEND_MVM);
  assign cap_p_o   = (st_q == ST_WAIT_MVM) && mvm_ack_i;
  assign upd_r_o   = (st_q == ST_UPD_R);
  assign done_o    = (st_q == ST_DONE);
  assign busy_o    = (st_q != ST_IDLE) && (st_q != ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (start_i) st_d = ST_SEND_INV;
      ST_SEND_INV: st_d = ST_WAIT_INV;
      ST_WAIT_INV: if (inv_ack_i) st_d = ST_UPD_X;
      ST_UPD_X:    st_d = ST_SEND_MVM;
      ST_SEND_MVM: st_d = ST_WAIT_MVM;
      ST_WAIT_MVM: if (mvm_ack_i) st_d = ST_UPD_R;
      ST_UPD_R:    st_d = ST_CHECK;
      ST_CHECK:    st_d = (conv_hit_i || iter_q >= max_iter_i) ? ST_DONE : ST_SEND_INV;
      ST_DONE:     st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; iter_q <= '0; conv_q <= 1'b0; nconv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_o) begin
        iter_q <= '0; conv_q <= 1'b0; nconv_q <= 1'b0;
      end else if (upd_r_o) begin
        iter_q <= iter_q + 1'b1;
      end else if (st_q == ST_CHECK) begin
        if (conv_hit_i)               conv_q  <= 1'b1;
        else if (iter_q >= max_iter_i) nconv_q <= 1'b1;
      end
    end
  end

  assign conv_o  = conv_q;
  assign nconv_o = nconv_q;
  assign iter_o  = iter_q;

  // R3
  inv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |=> !inv_req_o);
  // R5
  mvm_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mvm_req_o |=> !mvm_req_o);
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({conv_o, nconv_o}) <= 1);
  // R6
  done_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({conv_o, nconv_o}) == 1);
  // R7
  limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nconv_o) |-> iter_o >= max_iter_i);
  // R3
  no_req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(inv_req_o || mvm_req_o));
endmodule

// File: rtl/refine_seq.sv
module refine_seq #(
  parameter int N  = 4,
  parameter int W  = 24,
  parameter int QW = 4,
  parameter int IW = 8,
  localparam int LW = $clog2(W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N*W-1:0]  b_i,
  input  logic [LW-1:0]   tol_i,
  input  logic [IW-1:0]   max_iter_i,
  output logic            inv_req_o,
  output logic [N*QW-1:0] inv_vec_o,
  output logic [LW-1:0]   inv_shift_o,
  input  logic            inv_ack_i,
  input  logic [N*W-1:0]  inv_dx_i,
  output logic            mvm_req_o,
  output logic [N*W-1:0]  mvm_vec_o,
  input  logic            mvm_ack_i,
  input  logic [N*W-1:0]  mvm_res_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            conv_o,
  output logic            nconv_o,
  output logic [IW-1:0]   iter_o,
  output logic [N*W-1:0]  x_o
);
  logic load, cap_dx, cap_p, upd_x, upd_r, conv_hit;
  logic [N*W-1:0] r_vec;

  refine_ctrl #(.IW(IW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .inv_ack_i, .mvm_ack_i,
    .conv_hit_i(conv_hit), .max_iter_i,
    .load_o(load), .inv_req_o, .cap_dx_o(cap_dx), .upd_x_o(upd_x),
    .mvm_req_o, .cap_p_o(cap_p), .upd_r_o(upd_r),
    .busy_o, .done_o, .conv_o, .nconv_o, .iter_o
  );

  refine_vec #(.N(N), .W(W)) u_vec (
    .clk_i, .rst_ni, .load_i(load), .b_i,
    .cap_dx_i(cap_dx), .dx_i(inv_dx_i), .cap_p_i(cap_p), .p_i(mvm_res_i),
    .upd_x_i(upd_x), .upd_r_i(upd_r),
    .x_o, .r_o(r_vec), .dx_o(mvm_vec_o)
  );

  refine_norm #(.N(N), .W(W), .QW(QW), .LW(LW)) u_norm (
    .r_i(r_vec), .tol_i, .q_o(inv_vec_o), .shift_o(inv_shift_o), .conv_o(conv_hit)
  );
endmodule

// File: tb/sim_refine_seq.sv
`timescale 1ns/1ps
module sim_refine_seq;
  localparam int N = 4, W = 24, QW = 4, IW = 8, LW = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [N*W-1:0] b_v = '0, inv_dx = '0, mvm_res = '0, mvm_vec, x_v;
  logic [LW-1:0] tol = '0, inv_shift;
  logic [IW-1:0] max_it = '0, iter;
  logic [N*QW-1:0] inv_vec;
  logic inv_req, inv_ack = 0, mvm_req, mvm_ack = 0, busy, done, conv, nconv;

  always #2 clk = ~clk;

  refine_seq #(.N(N), .W(W), .QW(QW), .IW(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .b_i(b_v), .tol_i(tol),
    .max_iter_i(max_it), .inv_req_o(inv_req), .inv_vec_o(inv_vec),
    .inv_shift_o(inv_shift), .inv_ack_i(inv_ack), .inv_dx_i(inv_dx),
    .mvm_req_o(mvm_req), .mvm_vec_o(mvm_vec), .mvm_ack_i(mvm_ack),
    .mvm_res_i(mvm_res), .busy_o(busy), .done_o(done), .conv_o(conv),
    .nconv_o(nconv), .iter_o(iter), .x_o(x_v));

  int total = 0, bad = 0, lat = 0;
  logic [N*QW-1:0] exp_vq[$];
  int exp_sq[$];
  longint bv[N], exp_x[N];
  int exp_it;
  bit exp_conv, done_seen;

  task automatic chk(input string req, input longint got, input longint expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, expv);
    end
  endtask

  function automatic longint wrapw(input longint v);
    logic signed [W-1:0] t;
    t = v[W-1:0];
    return longint'(t);
  endfunction

  function automatic longint a_el(input int i, input int j);
    if (i == j) return 16;
    return ((i + j) % 3 == 0) ? 2 : -1;
  endfunction

  function automatic longint inv_fn(input longint q, input int s);
    return wrapw((q * (longint'(1) << s)) / 16);
  endfunction

  function automatic longint max_abs(input longint v[N]);
    longint m = 0;
    for (int i = 0; i < N; i++) begin
      longint a = (v[i] < 0) ? -v[i] : v[i];
      if (a > m) m = a;
    end
    return m;
  endfunction

  // approximate-inverse unit model
  initial forever begin
    @(negedge clk);
    if (inv_req) begin
      longint dx[N];
      for (int i = 0; i < N; i++) begin
        logic signed [QW-1:0] t;
        t = inv_vec[i*QW +: QW];
        dx[i] = inv_fn(longint'(t), int'(inv_shift));
      end
      lat++;
      repeat (1 + lat % 3) @(negedge clk);
      for (int i = 0; i < N; i++) inv_dx[i*W +: W] = dx[i][W-1:0];
      inv_ack = 1;
      @(negedge clk);
      inv_ack = 0;
    end
  end

  // exact matrix-vector unit model
  initial forever begin
    @(negedge clk);
    if (mvm_req) begin
      longint p[N];
      for (int i = 0; i < N; i++) begin
        p[i] = 0;
        for (int j = 0; j < N; j++) begin
          logic signed [W-1:0] t;
          t = mvm_vec[j*W +: W];
          p[i] += a_el(i, j) * longint'(t);
        end
        p[i] = wrapw(p[i]);
      end
      repeat (1 + lat % 2) @(negedge clk);
      for (int i = 0; i < N; i++) mvm_res[i*W +: W] = p[i][W-1:0];
      mvm_ack = 1;
      @(negedge clk);
      mvm_ack = 0;
    end
  end

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && inv_req) begin
      if (exp_vq.size() == 0) begin
        chk("R3 unexpected inv request", 1, 0);
      end else begin
        logic [N*QW-1:0] ev;
        int es;
        ev = exp_vq.pop_front();
        es = exp_sq.pop_front();
        chk("R2 quantized vector", longint'(inv_vec), longint'(ev));
        chk("R2 shift", longint'(inv_shift), longint'(es));
      end
    end
    if (rst_n && done) begin
      done_seen = 1;
      for (int i = 0; i < N; i++) begin
        logic signed [W-1:0] t;
        t = x_v[i*W +: W];
        chk("R4 solution element", longint'(t), exp_x[i]);
      end
      chk("R8 pass count", longint'(iter), longint'(exp_it));
      chk("R6 conv flag", longint'(conv), longint'(exp_conv));
      chk("R7 nconv flag", longint'(nconv), longint'(!exp_conv));
    end
  end

  bit hung = 0;

  task automatic run_case(input int tl, input int mi, input bit intr);
    longint r[N], x[N], dx[N], p[N];
    int it = 0;
    bit cv = 0;
    for (int i = 0; i < N; i++) begin r[i] = bv[i]; x[i] = 0; end
    for (int g = 0; g < 300; g++) begin
      longint m = max_abs(r);
      int L = 0, s;
      logic [N*QW-1:0] qv;
      for (int b = 0; b < 40; b++) if (m[b]) L = b;
      s = (L >= 3) ? L - 2 : 0;
      for (int i = 0; i < N; i++) begin
        longint q = r[i] >>> s;
        qv[i*QW +: QW] = q[QW-1:0];
        dx[i] = inv_fn(q, s);
      end
      exp_vq.push_back(qv);
      exp_sq.push_back(s);
      for (int i = 0; i < N; i++) begin
        p[i] = 0;
        for (int j = 0; j < N; j++) p[i] += a_el(i, j) * dx[j];
        p[i] = wrapw(p[i]);
      end
      for (int i = 0; i < N; i++) begin
        x[i] = wrapw(x[i] + dx[i]);
        r[i] = wrapw(r[i] - p[i]);
      end
      it++;
      if (max_abs(r) < (longint'(1) << tl)) begin cv = 1; break; end
      if (it >= mi) break;
    end
    for (int i = 0; i < N; i++) exp_x[i] = x[i];
    exp_it = it; exp_conv = cv;

    @(negedge clk);
    for (int i = 0; i < N; i++) b_v[i*W +: W] = bv[i][W-1:0];
    tol = LW'(tl); max_it = IW'(mi); done_seen = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R1 busy after start", longint'(busy), 1);
    chk("R8 count cleared", longint'(iter), 0);
    if (intr) begin
      repeat (5) @(negedge clk);
      b_v = {N{24'h35A5A5}};
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R9 still busy after ignored start", longint'(busy), 1);
    end
    for (int g = 0; g < 5000 && !done_seen; g++) @(negedge clk);
    if (!done_seen) begin
      hung = 1;
      chk("watchdog expired", 0, 1);
    end else begin
      @(negedge clk);
      chk("R1 busy low after done", longint'(busy), 0);
      chk("R10 conv held", longint'(conv), longint'(exp_conv));
      chk("R10 nconv held", longint'(nconv), longint'(!exp_conv));
      chk("R9 R3 request count", longint'(exp_vq.size()), 0);
    end
    exp_vq.delete(); exp_sq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", longint'(busy), 0);
    chk("R1 reset done", longint'(done), 0);
    chk("R1 reset conv", longint'(conv), 0);
    chk("R1 reset nconv", longint'(nconv), 0);
    chk("R1 reset requests", longint'({inv_req, mvm_req}), 0);
    chk("R1 reset iter", longint'(iter), 0);
    chk("R1 reset x", longint'(x_v != 0), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    bv = '{1000, -2000, 500, 300};
    run_case(5, 20, 0);                                   // R6 mixed sign
    if (!hung) begin
      bv = '{800000, -600000, 1234567, -3};
      run_case(6, 30, 0);                                 // R2 large shifts
    end
    if (!hung) begin
      bv = '{5, -3, 2, 1};
      run_case(0, 3, 0);                                  // R7 stall below shift
    end
    if (!hung) begin
      bv = '{0, 0, 0, 0};
      run_case(0, 5, 0);                                  // R6 zero rhs, one pass
    end
    if (!hung) begin
      bv = '{100, 40, -70, 9};
      run_case(0, 0, 0);                                  // R7 zero limit acts as one
    end
    if (!hung) begin
      bv = '{-8388608, 0, 0, 0};
      run_case(8, 30, 0);                                 // R2 most negative
    end
    if (!hung) begin
      bv = '{1000, -2000, 500, 300};
      run_case(5, 20, 1);                                 // R9 start during run
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule